// File: doc/BRIEF.md
# Watchdog Timer with Keyed Clear

This block is a watchdog counter for a system-clock domain. It advances on a slow tick (`tick_i`), a one-cycle clock-enable pulse. Software controls it through one 8-bit control write port that carries three fields: a clear key, a start bit and an interval select. Once started, the counter counts ticks. When it reaches the selected interval it raises a one-cycle reset request and wraps to zero.

Software keeps the system alive by restarting the count with a two-step key sequence. It writes the arming key 0xA and then the firing key 0x5, and the second key must follow the first within a short window measured in ticks. Once started, the timer cannot be stopped and its interval cannot be changed. Only the global reset returns it to the idle state. A status output, the active interval code and the live tick count are brought out so the block can be observed.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `enabled_o` is 0, `interval_o` is 2'b00, `count_o` is 0 and `rst_req_o` is 0.
- R2: A control write with bit 3 set makes `enabled_o` 1 from the next cycle. A write with bit 3 clear leaves it unchanged. Once set, it stays at 1 until reset.
- R3: While the timer is idle, a control write loads bits [1:0] into `interval_o`. While the timer is enabled, those bits are ignored and `interval_o` holds its value.
- R4: While the timer is enabled, `count_o` rises by one on each cycle with `tick_i` high. While it is idle, `count_o` stays at 0.
- R5: The interval code selects a limit in ticks: 2'b11 gives 64, 2'b10 gives 512, 2'b01 gives 8192 and 2'b00 gives 32768. The tick that would bring the count to the limit instead wraps `count_o` to 0 and drives `rst_req_o` high for exactly one cycle.
- R6: While the timer is enabled, a write of 0xA to bits [7:4] followed by a write of 0x5 to bits [7:4] sets `count_o` to 0 in the cycle after the 0x5 write. This holds when at most one tick falls between the two writes.
- R7: If two or more ticks fall between the 0xA write and the 0x5 write, the count is not cleared. The pending sequence ends, so a further 0x5 write also has no effect.
- R8: Any key value other than 0x5 written after 0xA cancels the pending sequence. A new 0xA write restarts the sequence and its tick window.
- R9: Key writes made while the timer is idle have no effect. This includes a write that carries both the start bit and key 0xA.
- R10: A 0x5 write with no pending 0xA does not clear the count. A valid clear that lands in the same cycle as a tick wins: the count becomes 0 and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Watchdog tick enable pulse |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 8 | Control word: [7:4] key, [3] start, [2] unused, [1:0] interval |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| enabled_o | output | 1 | Timer running status |
| interval_o | output | 2 | Active interval code |
| count_o | output | CNT_W (15) | Current tick count |

## Verification
Every result is due one clock after the edge that samples its stimulus. A control write or a tick registered at one edge shows up in `enabled_o`, `interval_o`, `count_o` and `rst_req_o` right after that edge. The reset request lasts only until the following edge. The bench drives inputs on the falling edge and holds each one for a single cycle. It samples at the next falling edge, exactly one register stage later, and then checks one falling edge later again that the request pulse has dropped. The key window is set by placing an exact number of tick pulses between the two key writes. For each interval code, a full sweep runs the limit minus one ticks and then the final tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [3:0] KEY_ARM  = 4'hA;
  localparam logic [3:0] KEY_FIRE = 4'h5;

  // field layout of the control word
  typedef struct packed {
    logic [3:0] key;
    logic       start;
    logic       rsvd;
    logic [1:0] sel;
  } ctl_word_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  ctl_word_t wr_word_i,
  output logic      en_o,
  output logic [1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      sel_o <= 2'b00;
    end else if (wr_en_i) begin
      if (wr_word_i.start) en_o <= 1'b1;
      // interval locked once running
      if (!en_o) sel_o <= wr_word_i.sel;
    end
  end
endmodule

// File: rtl/wdt_key.sv
module wdt_key
  import wdt_pkg::*;
#(
  parameter int WIN_TICKS = 1,
  localparam int WIN_W    = $clog2(WIN_TICKS + 2)
)(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [3:0] key_i,
  output logic       clear_o
);
  localparam logic [WIN_W-1:0] WIN_LIM = WIN_W'(WIN_TICKS);
  localparam logic [WIN_W-1:0] WIN_SAT = WIN_W'(WIN_TICKS + 1);

  logic             armed_q;
  logic [WIN_W-1:0] win_q;
  logic             key_wr;

  assign key_wr  = wr_en_i && en_i;
  assign clear_o = key_wr && armed_q && (key_i == KEY_FIRE) && (win_q <= WIN_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else if (key_wr) begin
      armed_q <= (key_i == KEY_ARM);
      win_q   <= '0;
    end else if (armed_q && tick_i && win_q != WIN_SAT) begin
      win_q <= win_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int LIM_SLOW  = 32768,
  parameter int LIM_MID   = 8192,
  parameter int LIM_FAST  = 512,
  parameter int LIM_FLASH = 64,
  parameter int CNT_W     = $clog2(LIM_SLOW)
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             req_o
);
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  always_comb begin
    unique case (sel_i)
      2'b00:   last_val = CNT_W'(LIM_SLOW - 1);
      2'b01:   last_val = CNT_W'(LIM_MID - 1);
      2'b10:   last_val = CNT_W'(LIM_FAST - 1);
      default: last_val = CNT_W'(LIM_FLASH - 1);
    endcase
  end

  assign at_last = (count_o == last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      req_o   <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (clear_i) begin
        count_o <= '0;
      end else if (en_i && tick_i) begin
        if (at_last) begin
          count_o <= '0;
          req_o   <= 1'b1;
        end else begin
          count_o <= count_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int LIM_SLOW  = 32768,
  parameter int LIM_MID   = 8192,
  parameter int LIM_FAST  = 512,
  parameter int LIM_FLASH = 64,
  parameter int WIN_TICKS = 1,
  parameter int CNT_W     = $clog2(LIM_SLOW)
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic             rst_req_o,
  output logic             enabled_o,
  output logic [1:0]       interval_o,
  output logic [CNT_W-1:0] count_o
);
  ctl_word_t word;
  logic      clear_w;

  assign word = ctl_word_t'(wr_data_i);

  wdt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_word_i (word),
    .en_o      (enabled_o),
    .sel_o     (interval_o)
  );

  wdt_key #(.WIN_TICKS(WIN_TICKS)) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enabled_o),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .key_i   (word.key),
    .clear_o (clear_w)
  );

  wdt_counter #(
    .LIM_SLOW(LIM_SLOW), .LIM_MID(LIM_MID), .LIM_FAST(LIM_FAST),
    .LIM_FLASH(LIM_FLASH), .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enabled_o),
    .tick_i  (tick_i),
    .clear_i (clear_w),
    .sel_i   (interval_o),
    .count_o (count_o),
    .req_o   (rst_req_o)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W = 15
)(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             clear_i,
  input logic             rst_req_o,
  input logic             enabled_o,
  input logic [1:0]       interval_o,
  input logic [CNT_W-1:0] count_o
);
  // R2
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enabled_o |=> enabled_o);
  // R3
  sel_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enabled_o |=> $stable(interval_o));
  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o |-> (count_o == '0) && !rst_req_o);
  // R4
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o) || (count_o == '0));
  // R5
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R5
  req_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> count_o == '0);
  // R10
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0) && !rst_req_o);
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .clear_i    (clear_w),
  .rst_req_o  (rst_req_o),
  .enabled_o  (enabled_o),
  .interval_o (interval_o),
  .count_o    (count_o)
);

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;
  localparam int CNT_W = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_req, enabled;
  logic [1:0] interval;
  logic [CNT_W-1:0] count;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_keyed u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rst_req_o(rst_req), .enabled_o(enabled),
    .interval_o(interval), .count_o(count)
  );

  always @(negedge clk) if (rst_req) pulses++;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wr_tick(logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00; tick = 1'b0;
  endtask

  // spaced ticks: each pulse followed by two idle cycles
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  // back-to-back ticks, sampled right after the last edge
  task automatic run_ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int base;
    do_reset();
    // R1
    check("R1 enabled", enabled, 0);
    check("R1 interval", interval, 0);
    check("R1 count", count, 0);
    check("R1 req", rst_req, 0);

    wr(8'h03);
    check("R3 sel idle", interval, 3);
    check("R2 no start", enabled, 0);
    ticks(5);
    check("R4 idle no count", count, 0);

    // R9: key A carried on the start write is ignored
    wr(8'hAB);
    check("R2 start", enabled, 1);
    ticks(1);
    check("R4 one tick", count, 1);
    wr(8'h50);
    check("R9 idle key", count, 1);
    check("R3 sel locked", interval, 3);
    check("R2 zero no stop", enabled, 1);
    ticks(20);
    check("R4 count", count, 21);

    // R6
    wr(8'hA0); wr(8'h50);
    check("R6 immediate", count, 0);
    ticks(10);
    wr(8'hA0); ticks(1); wr(8'h50);
    check("R6 one tick", count, 0);

    // R7
    ticks(10);
    wr(8'hA0); ticks(2); wr(8'h50);
    check("R7 late", count, 12);
    wr(8'h50);
    check("R7 ended", count, 12);

    // R8
    wr(8'hA0); wr(8'h30); wr(8'h50);
    check("R8 abort", count, 12);
    ticks(3);
    wr(8'hA0); ticks(2); wr(8'hA0); ticks(1);
    check("R8 pre", count, 18);
    wr(8'h50);
    check("R8 restart", count, 0);

    // R10
    ticks(5);
    wr(8'h50);
    check("R10 no arm", count, 5);
    wr(8'hA0); wr_tick(8'h50);
    check("R10 clear vs tick", count, 0);

    // R5 wrap at 64
    base = pulses;
    ticks(63);
    check("R5 before limit", count, 63);
    check("R5 no early req", pulses - base, 0);
    run_ticks(1);
    check("R5 req", rst_req, 1);
    check("R5 wrap", count, 0);
    @(negedge clk);
    check("R5 one cycle", rst_req, 0);
    ticks(63);
    wr(8'hA0); wr_tick(8'h50);
    check("R10 clear at limit", count, 0);
    @(negedge clk);
    check("R10 no req", pulses - base, 1);

    // R5 sweep over all interval codes
    for (int enc = 0; enc < 4; enc++) begin
      int lim;
      lim = (enc == 0) ? 32768 : (enc == 1) ? 8192 : (enc == 2) ? 512 : 64;
      do_reset();
      wr(8'h08 | 8'(enc));
      wr(8'h08 | 8'(enc ^ 3));
      check("R3 sweep lock", interval, enc);
      base = pulses;
      run_ticks(lim - 1);
      check("R5 sweep count", count, lim - 1);
      check("R5 sweep no req", pulses - base, 0);
      run_ticks(1);
      check("R5 sweep req", rst_req, 1);
      check("R5 sweep wrap", count, 0);
    end
    finish_run();
  end
endmodule